// File: doc/BRIEF.md
# DDR Write Recovery Guard

This block sits between a command scheduler and the DDR command bus and keeps write-to-read, write-to-precharge and precharge-to-next-command spacing legal for each of four banks. The scheduler presents one proposed command per cycle with its bank, the number of write data pairs (for a write), an auto-precharge flag and a cut-short flag. The block answers in the same cycle with a grant. A granted command is taken as issued on the bus. The three spacings (write-to-read, write recovery and precharge time) are inputs counted in clocks.

Each bank tracks the position of its write burst on the data pins. A read or precharge may deliberately cut a running or recovering write short. When it does, the block works out which data pairs of that burst fall inside the cutting command's recovery window. It reports them one cycle later as a bit vector, so the write data path can mask them. A write with auto precharge keeps its bank closed to all commands until the internal precharge and its precharge time have both elapsed.

Top module: `wr_recovery_guard`

## Requirements
- R1: `cmd_grant` is combinational in the cycle a command is presented. It is high only when `cmd_valid` is high and the command is legal. Op encoding on `cmd_op`: 0 = READ, 1 = WRITE, 2 = PRECHARGE, 3 = ACTIVATE. Data pair k (0-based) of a WRITE granted in cycle c lies in cycle c+1+k. In a later cycle t, the pair position is p = t-c-1.
- R2: A READ with `cmd_trunc` low, to a bank holding a tracked write of n pairs, is granted only when p >= n + `t_wtr`.
- R3: A READ with `cmd_trunc` high is granted whenever its bank is not busy. The pairs k with max(p - `t_wtr`, 0) <= k < n are masked. The bank's tracked length then becomes max(p - `t_wtr`, 0). A tracked length of 0 means no write is tracked.
- R4: A PRECHARGE with `cmd_trunc` low is granted only when p >= n + `t_wr`, or when no write is tracked.
- R5: A PRECHARGE with `cmd_trunc` high is granted whenever its bank is not busy. It masks the pairs k with max(p - `t_wr`, 0) <= k < n. Any granted PRECHARGE clears the bank's tracked write.
- R6: After a PRECHARGE is granted in cycle P, the bank is busy and grants nothing to that bank before cycle P + `t_rp` (`t_rp` >= 1). From cycle P + `t_rp` on, that bank can be granted again.
- R7: A WRITE granted with `cmd_ap` high in cycle c, with n pairs, keeps its bank busy through cycle c+n+`t_wr`. The internal precharge occurs in cycle c+1+n+`t_wr`. The bank is free again from that cycle + `t_rp`.
- R8: Banks are independent, selected by the 2-bit `cmd_bank`. State in one bank never affects grants to another.
- R9: One cycle after a granted READ or PRECHARGE whose mask is non-empty, `mask_valid` is high, `mask_bank` holds its bank and bit k of `mask_bits` marks pair k. After any other cycle, `mask_valid` is low and `mask_bits` is zero.
- R10: A WRITE or ACTIVATE is granted whenever its bank is not busy. A granted WRITE (1 to 8 pairs) replaces the bank's tracked write and restarts its pair position at 0.
- R11: After reset, no bank is busy, no write is tracked, and `mask_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is proposed this cycle |
| cmd_op | input | 2 | 0 READ, 1 WRITE, 2 PRECHARGE, 3 ACTIVATE |
| cmd_bank | input | 2 | Target bank |
| cmd_trunc | input | 1 | READ/PRECHARGE may cut a write short |
| cmd_ap | input | 1 | WRITE with auto precharge |
| cmd_pairs | input | 4 | Data pairs of a WRITE (1 to 8) |
| t_wtr | input | 4 | Write-to-read spacing in clocks |
| t_wr | input | 4 | Write recovery in clocks |
| t_rp | input | 4 | Precharge time in clocks, at least 1 |
| cmd_grant | output | 1 | Command may be issued this cycle |
| mask_valid | output | 1 | Mask report valid |
| mask_bank | output | 2 | Bank of the mask report |
| mask_bits | output | 8 | Bit k set: pair k must be masked |

## Verification
The grant is due in the same cycle as the proposal. The bench drives inputs at the falling edge and compares the grant one time unit later, before the rising edge that would register the command. The mask report is due at the rising edge after the granted command. It is compared at the following falling edge, against an expectation the reference model stored when it advanced on that rising edge. The model keeps absolute cycle numbers of writes and precharges per bank. It derives pair positions, auto-precharge firing and bank release from those numbers.

// File: rtl/wrg_pkg.sv
package wrg_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PRE   = 2'd2,
    OP_ACT   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_WRITE = 2'd1,
    EV_CUT   = 2'd2,
    EV_PRE   = 2'd3
  } bank_ev_e;
endpackage

// File: rtl/wrg_mask_calc.sv
module wrg_mask_calc #(
  parameter int MAXP   = 8,
  parameter int T_W    = 4,
  parameter int PAIR_W = 4,
  parameter int P_W    = 6
) (
  input  logic [P_W-1:0]    pidx,
  input  logic [T_W-1:0]    win,
  input  logic [PAIR_W-1:0] wlen,
  output logic [MAXP-1:0]   bits,
  output logic [P_W-1:0]    first
);
  // first pair that falls inside the recovery window of the cutting command
  assign first = (pidx >= P_W'(win)) ? pidx - P_W'(win) : '0;

  for (genvar k = 0; k < MAXP; k++) begin : g_pair
    assign bits[k] = (P_W'(k) >= first) && (PAIR_W'(k) < wlen);
  end
endmodule

// File: rtl/wrg_bank_track.sv
module wrg_bank_track
  import wrg_pkg::*;
#(
  parameter int T_W    = 4,
  parameter int PAIR_W = 4,
  parameter int P_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_ev_e          ev,
  input  logic [PAIR_W-1:0] ev_len,
  input  logic              ev_ap,
  input  logic [T_W-1:0]    t_wr,
  input  logic [T_W-1:0]    t_rp,
  output logic [P_W-1:0]    pidx,
  output logic [PAIR_W-1:0] wlen,
  output logic              busy
);
  localparam logic [P_W-1:0] P_MAX = '1;

  logic           ap_pend;
  logic [T_W-1:0] rp_cnt;
  logic [T_W-1:0] rp_load;
  logic           ap_fire;

  assign ap_fire = ap_pend && (pidx >= P_W'(wlen) + P_W'(t_wr));
  assign rp_load = (t_rp == '0) ? '0 : t_rp - T_W'(1);
  assign busy    = ap_pend || (rp_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pidx    <= '0;
      wlen    <= '0;
      ap_pend <= 1'b0;
      rp_cnt  <= '0;
    end else begin
      if (rp_cnt != '0) rp_cnt <= rp_cnt - T_W'(1);
      if (pidx != P_MAX) pidx <= pidx + P_W'(1);
      if (ap_fire) begin
        ap_pend <= 1'b0;
        wlen    <= '0;
        rp_cnt  <= rp_load;
      end
      case (ev)
        EV_WRITE: begin
          pidx    <= '0;
          wlen    <= ev_len;
          ap_pend <= ev_ap;
        end
        EV_CUT: wlen <= ev_len;
        EV_PRE: begin
          wlen   <= '0;
          rp_cnt <= rp_load;
        end
        default: ;
      endcase
    end
  end

  // R10
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_WRITE) |=> (pidx == '0 && wlen == $past(ev_len)));

  // R7
  ap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ap_pend && (pidx < P_W'(wlen) + P_W'(t_wr))) |=> busy);

  // R6
  pre_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_PRE && t_rp > T_W'(1)) |=> busy);

  // R5
  pre_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ev == EV_PRE) |=> (wlen == '0));
endmodule

// File: rtl/wr_recovery_guard.sv
module wr_recovery_guard
  import wrg_pkg::*;
#(
  parameter int NB   = 4,
  parameter int MAXP = 8,
  parameter int T_W  = 4,
  localparam int BANK_W = $clog2(NB),
  localparam int PAIR_W = $clog2(MAXP + 1),
  localparam int P_W    = $clog2(MAXP + (1 << T_W)) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_trunc,
  input  logic              cmd_ap,
  input  logic [PAIR_W-1:0] cmd_pairs,
  input  logic [T_W-1:0]    t_wtr,
  input  logic [T_W-1:0]    t_wr,
  input  logic [T_W-1:0]    t_rp,
  output logic              cmd_grant,
  output logic              mask_valid,
  output logic [BANK_W-1:0] mask_bank,
  output logic [MAXP-1:0]   mask_bits
);
  cmd_op_e           op;
  logic [P_W-1:0]    pidx_a [NB];
  logic [PAIR_W-1:0] wlen_a [NB];
  logic [NB-1:0]     busy_a;
  bank_ev_e          ev_a   [NB];

  logic [T_W-1:0]    win;
  logic [MAXP-1:0]   mbits;
  logic [P_W-1:0]    first;
  logic              mask_any;
  logic              rw_op;
  logic              legal;
  bank_ev_e          ev_sel;
  logic [PAIR_W-1:0] ev_len;

  assign op  = cmd_op_e'(cmd_op);
  assign win = (op == OP_READ) ? t_wtr : t_wr;

  wrg_mask_calc #(
    .MAXP(MAXP), .T_W(T_W), .PAIR_W(PAIR_W), .P_W(P_W)
  ) mask_i (
    .pidx  (pidx_a[cmd_bank]),
    .win   (win),
    .wlen  (wlen_a[cmd_bank]),
    .bits  (mbits),
    .first (first)
  );

  assign mask_any  = |mbits;
  assign rw_op     = (op == OP_READ) || (op == OP_PRE);
  assign legal     = !busy_a[cmd_bank] && (!rw_op || cmd_trunc || !mask_any);
  assign cmd_grant = cmd_valid && legal;

  always_comb begin
    case (op)
      OP_WRITE: ev_sel = EV_WRITE;
      OP_PRE:   ev_sel = EV_PRE;
      OP_READ:  ev_sel = mask_any ? EV_CUT : EV_NONE;
      default:  ev_sel = EV_NONE;
    endcase
  end

  assign ev_len = (op == OP_WRITE) ? cmd_pairs : PAIR_W'(first);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign ev_a[b] = (cmd_grant && cmd_bank == BANK_W'(b)) ? ev_sel : EV_NONE;

    wrg_bank_track #(
      .T_W(T_W), .PAIR_W(PAIR_W), .P_W(P_W)
    ) trk_i (
      .clk    (clk),
      .rst    (rst),
      .ev     (ev_a[b]),
      .ev_len (ev_len),
      .ev_ap  (cmd_ap),
      .t_wr   (t_wr),
      .t_rp   (t_rp),
      .pidx   (pidx_a[b]),
      .wlen   (wlen_a[b]),
      .busy   (busy_a[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_valid <= 1'b0;
      mask_bank  <= '0;
      mask_bits  <= '0;
    end else begin
      mask_valid <= cmd_grant && rw_op && mask_any;
      mask_bank  <= cmd_bank;
      mask_bits  <= (cmd_grant && rw_op) ? mbits : '0;
    end
  end

  // R9
  mask_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    mask_valid |-> (mask_bits != '0));

  // R9
  mask_cause_chk: assert property (@(posedge clk) disable iff (rst)
    mask_valid |-> $past(cmd_grant));

  // R2
  plain_read_nomask_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && op == OP_READ && !cmd_trunc) |=> !mask_valid);

  // R4
  plain_pre_nomask_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_grant && op == OP_PRE && !cmd_trunc) |=> !mask_valid);
endmodule

// File: tb/wr_recovery_guard_tb.sv
module wr_recovery_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NBK = 4;
  localparam int NP  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_trunc = 1'b0;
  logic       cmd_ap = 1'b0;
  logic [3:0] cmd_pairs = 4'd1;
  logic [3:0] t_wtr = 4'd2;
  logic [3:0] t_wr = 4'd3;
  logic [3:0] t_rp = 4'd2;
  logic       cmd_grant;
  logic       mask_valid;
  logic [1:0] mask_bank;
  logic [7:0] mask_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state: absolute cycle numbers per bank
  int   m_wc   [NBK];
  int   m_wl   [NBK];
  int   m_free [NBK];
  bit   m_ap   [NBK];
  int   cyc;
  bit   e_mv;
  int   e_mb;
  logic [7:0] e_bits;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wr_recovery_guard dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_trunc(cmd_trunc), .cmd_ap(cmd_ap),
    .cmd_pairs(cmd_pairs), .t_wtr(t_wtr), .t_wr(t_wr), .t_rp(t_rp),
    .cmd_grant(cmd_grant), .mask_valid(mask_valid), .mask_bank(mask_bank),
    .mask_bits(mask_bits)
  );

  task automatic model_reset();
    for (int b = 0; b < NBK; b++) begin
      m_wc[b] = 0; m_wl[b] = 0; m_free[b] = 0; m_ap[b] = 1'b0;
    end
    cyc = 0; e_mv = 1'b0; e_mb = 0; e_bits = 8'h00;
  endtask

  // one cycle: drive at falling edge, compare, advance model at rising edge
  task automatic drive(input bit v, input int op, input int b, input bit tr,
                       input bit ap, input int np, input string tag);
    int p, win, first;
    bit busy, any, rwop, g;
    logic [7:0] bits;
    string rq;
    @(negedge clk);
    cmd_valid = v; cmd_op = op[1:0]; cmd_bank = b[1:0];
    cmd_trunc = tr; cmd_ap = ap; cmd_pairs = np[3:0];
    #1;
    // R9: mask report of the previous cycle
    checks++;
    if (mask_valid !== e_mv || mask_bits !== e_bits ||
        (e_mv && mask_bank !== e_mb[1:0])) begin
      fails++;
      $display("FAIL R9 mask got v=%0b bank=%0d bits=%h exp v=%0b bank=%0d bits=%h",
               mask_valid, mask_bank, mask_bits, e_mv, e_mb, e_bits);
    end
    p = cyc - m_wc[b] - 1;
    busy = m_ap[b] || (cyc < m_free[b]);
    win = (op == 0) ? int'(t_wtr) : int'(t_wr);
    first = p - win;
    if (first < 0) first = 0;
    any = 1'b0;
    for (int k = 0; k < NP; k++) begin
      bits[k] = (k >= first) && (k < m_wl[b]);
      any = any | bits[k];
    end
    rwop = (op == 0) || (op == 2);
    g = v && !busy && (!rwop || tr || !any);
    if (tag != "") rq = tag;
    else if (busy) rq = "R6";
    else if (op == 0) rq = tr ? "R3" : "R2";
    else if (op == 2) rq = tr ? "R5" : "R4";
    else rq = "R10";
    checks++;
    if (cmd_grant !== g) begin
      fails++;
      $display("FAIL %s grant op=%0d bank=%0d trunc=%0b got=%0b exp=%0b",
               rq, op, b, tr, cmd_grant, g);
    end
    @(posedge clk);
    // R7: internal precharge of an auto-precharge write
    for (int bb = 0; bb < NBK; bb++) begin
      if (m_ap[bb] && (cyc - m_wc[bb] - 1) >= m_wl[bb] + int'(t_wr)) begin
        m_ap[bb] = 1'b0; m_wl[bb] = 0; m_free[bb] = cyc + int'(t_rp);
      end
    end
    if (g) begin
      case (op)
        1: begin m_wc[b] = cyc; m_wl[b] = np; m_ap[b] = ap; end
        2: begin m_wl[b] = 0; m_free[b] = cyc + int'(t_rp); end
        0: if (any) m_wl[b] = first;
        default: ;
      endcase
    end
    e_mv = g && rwop && any;
    e_bits = (g && rwop) ? bits : 8'h00;
    e_mb = b;
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 1'b0, 1, "R1");
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state of the mask report
    checks++;
    if (mask_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11 mask_valid in reset got=%0b exp=0", mask_valid);
    end
    rst = 1'b0;
    model_reset();

    // R11: every bank free and untracked after reset
    for (int b = 0; b < NBK; b++) drive(1'b1, 0, b, 1'b0, 1'b0, 1, "R11");
    // R1: no grant without a valid proposal
    drive(1'b0, 1, 0, 1'b0, 1'b0, 4, "R1");

    // R2: write of 4 pairs, plain reads denied until p >= 4 + t_wtr
    drive(1'b1, 1, 0, 1'b0, 1'b0, 4, "R10");
    for (int i = 0; i < 7; i++) drive(1'b1, 0, 0, 1'b0, 1'b0, 1, "R2");

    // R3: cutting read at p=4 masks pairs 2..7; R4 precharge after cut length
    drive(1'b1, 1, 0, 1'b0, 1'b0, 8, "R10");
    idle(4);
    drive(1'b1, 0, 0, 1'b1, 1'b0, 1, "R3");
    drive(1'b1, 2, 0, 1'b0, 1'b0, 1, "R4");
    // R6: activate denied one cycle after precharge, granted at P + t_rp
    drive(1'b1, 3, 0, 1'b0, 1'b0, 1, "R6");
    drive(1'b1, 3, 0, 1'b0, 1'b0, 1, "R6");

    // R5: cutting precharge early masks every pair
    drive(1'b1, 1, 0, 1'b0, 1'b0, 8, "R10");
    idle(1);
    drive(1'b1, 2, 0, 1'b1, 1'b0, 1, "R5");
    idle(3);

    // R8: bank 1 write does not block bank 2, but blocks bank 1
    drive(1'b1, 1, 1, 1'b0, 1'b0, 8, "R10");
    drive(1'b1, 0, 2, 1'b0, 1'b0, 1, "R8");
    drive(1'b1, 0, 1, 1'b0, 1'b0, 1, "R8");

    // R7: auto-precharge write holds bank 3 until precharge plus t_rp
    drive(1'b1, 1, 3, 1'b0, 1'b1, 2, "R10");
    for (int i = 0; i < 10; i++) drive(1'b1, 3, 3, 1'b0, 1'b0, 1, "R7");
    idle(50);

    // random streams under three timing sets
    for (int ph = 0; ph < 3; ph++) begin
      @(negedge clk);
      case (ph)
        0: begin t_wtr = 4'd2; t_wr = 4'd3; t_rp = 4'd2; end
        1: begin t_wtr = 4'd0; t_wr = 4'd1; t_rp = 4'd1; end
        default: begin t_wtr = 4'd5; t_wr = 4'd9; t_rp = 4'd4; end
      endcase
      for (int i = 0; i < 2000; i++) begin
        drive(($urandom_range(0, 9) < 8), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0),
              ($urandom_range(0, 3) == 0), int'($urandom_range(1, 8)), "");
      end
      idle(50);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule